// File: doc/BRIEF.md
# Incrementing Burst Write Master

This block turns a simple command (start address, beat count minus one, and bytes-per-beat code) into one complete incrementing write burst on an AXI4 write interface. It drives the write-address, write-data and write-response channels itself and fills the data beats with a generated counting pattern. A command is taken only while the block is idle. The burst ends when the slave returns its write response, and the block then pulses a completion flag with the response code.

Each beat has its own byte-lane enables. The first beat of an unaligned burst enables lanes from the start offset up to the end of its size-aligned chunk. Every later beat enables the whole chunk at `aligned_start + n * 2^size`. Narrow transfers therefore move across the bus lanes from beat to beat. The write-address and write-data channels are raised in the same cycle and complete independently, so a slave that holds its address ready low until it has seen data cannot stall the block.

Top module: `axi_burst_writer`

## Requirements
- R1: While reset is high and after it is released with no command, m_awvalid, m_wvalid, m_wlast, m_bready, busy and done are all 0 and cmd_ready is 1.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1, and only then. busy is 1 and cmd_ready is 0 from the cycle after acceptance until the cycle after the write-response handshake. The address channel presents m_awaddr = cmd_addr, m_awlen = cmd_len, m_awsize = cmd_size and m_awburst = 2'b01 (incrementing). A cmd_valid seen while busy has no effect.
- R3: While m_awvalid is 1 and m_awready is 0, m_awvalid stays 1 in the next cycle and m_awaddr, m_awlen and m_awsize keep their values.
- R4: While m_wvalid is 1 and m_wready is 0, m_wvalid stays 1 in the next cycle and m_wdata, m_wstrb and m_wlast keep their values. A beat advances only on an edge where m_wvalid and m_wready are both 1.
- R5: m_wvalid rises in the same cycle as m_awvalid, in the cycle after acceptance, whatever m_awready does.
- R6: Exactly cmd_len+1 beats transfer. m_wlast is 1 on the final beat only, and m_wvalid is 0 in the cycle after the final beat's handshake.
- R7: On beat n, bit i of m_wstrb is 1 exactly when byte lane i (address modulo the bus byte count) holds a byte in [A_n, C_n + 2^size). Here A_0 = start address, A_n = C_0 + n*2^size for n > 0, and C_n is A_n rounded down to a multiple of 2^size.
- R8: On beat n, each 32-bit word k of m_wdata (k = 0 in bits 31:0) equals {8'hD5, k[7:0], n[15:0]}.
- R9: m_bready rises only after both the address handshake and the final data handshake have happened, and it stays 1 until m_bvalid is seen. m_awvalid and m_wvalid are 0 while m_bready is 1.
- R10: In the cycle after the edge where m_bvalid and m_bready are both 1, done is 1 for exactly one cycle, done_resp equals the sampled m_bresp, and done_err is 1 when that code is 2'b10 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_addr | input | ADDR_W | Burst start byte address |
| cmd_len | input | LEN_W | Beats minus one |
| cmd_size | input | 3 | log2 of bytes per beat, at most log2 of the bus byte count |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| done_resp | output | 2 | Response code returned for the burst |
| done_err | output | 1 | Response was a slave or decode error |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address ready |
| m_awaddr | output | ADDR_W | Burst address |
| m_awlen | output | LEN_W | Burst length |
| m_awsize | output | 3 | Burst size |
| m_awburst | output | 2 | Burst type, always incrementing |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte-lane enables |
| m_wlast | output | 1 | Final beat marker |
| m_bvalid | input | 1 | Response valid |
| m_bready | output | 1 | Response ready |
| m_bresp | input | 2 | Response code |

## Verification
The address handshake and the final data handshake can land on the same clock edge. The block has to register both completions in that one cycle before it raises m_bready. The bench forces this by holding m_awready low until it raises m_wready for the last beat, so both handshakes complete together, including one-beat bursts where the first beat is also the last. Other modes let the data finish well before the address is accepted and stall data beats on alternate cycles. In every case the bench checks that m_bready never rises early and that exactly one completion pulse follows.

// File: rtl/axi_bw_pkg.sv
package axi_bw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } bw_state_e;

  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  // One 32-bit word of the generated pattern: tag, word index, beat index.
  function automatic logic [31:0] beat_word(input logic [15:0] beat, input logic [7:0] word);
    return {8'hD5, word, beat};
  endfunction

endpackage

// File: rtl/axi_bw_addr_chan.sv
module axi_bw_addr_chan #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [2:0]        cmd_size,
  input  logic              awready,
  output logic              awvalid,
  output logic [ADDR_W-1:0] awaddr,
  output logic [LEN_W-1:0]  awlen,
  output logic [2:0]        awsize,
  output logic              aw_hs
);

  assign aw_hs = awvalid && awready;

  always_ff @(posedge clk) begin
    if (rst) begin
      awvalid <= 1'b0;
    end else if (start) begin
      awvalid <= 1'b1;
    end else if (aw_hs) begin
      awvalid <= 1'b0;
    end
  end

  // Payload stays loaded for the whole burst; the data channel reads it.
  always_ff @(posedge clk) begin
    if (rst) begin
      awaddr <= '0;
      awlen  <= '0;
      awsize <= '0;
    end else if (start) begin
      awaddr <= cmd_addr;
      awlen  <= cmd_len;
      awsize <= cmd_size;
    end
  end

  a_r3_aw_hold: assert property (@(posedge clk) disable iff (rst)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen) && $stable(awsize)));

endmodule

// File: rtl/axi_bw_data_chan.sv
module axi_bw_data_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [2:0]          cmd_size,
  input  logic [ADDR_W-1:0]   held_addr,
  input  logic [LEN_W-1:0]    held_len,
  input  logic [2:0]          held_size,
  input  logic                wready,
  output logic                wvalid,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                w_hs,
  output logic                w_last_hs
);

  localparam int NB    = DATA_W / 8;
  localparam int NW    = DATA_W / 32;
  localparam int OFF_W = (NB > 1) ? $clog2(NB) : 1;

  logic [LEN_W-1:0] beat_q;
  logic [LEN_W-1:0] beat_nxt;

  // Address of beat n: the raw start for beat 0, size-aligned steps after.
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [2:0] sz,
                                                  input logic [LEN_W-1:0] n);
    logic [ADDR_W-1:0] al;
    al = a & ({ADDR_W{1'b1}} << sz);
    return (n == '0) ? a : (al + (ADDR_W'(n) << sz));
  endfunction

  // Lanes from the byte offset up to the end of its size-aligned chunk.
  function automatic logic [NB-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                              input logic [2:0] sz);
    logic [NB-1:0] m;
    int lo;
    int span;
    int top;
    lo   = int'(off);
    span = 1 << sz;
    top  = lo - (lo % span) + span;
    for (int i = 0; i < NB; i++) begin
      m[i] = (i >= lo) && (i < top);
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] beat_data(input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] d;
    for (int k = 0; k < NW; k++) begin
      d[32*k +: 32] = axi_bw_pkg::beat_word(16'(n), 8'(k));
    end
    return d;
  endfunction

  logic [ADDR_W-1:0] nxt_addr;

  assign w_hs      = wvalid && wready;
  assign w_last_hs = w_hs && wlast;
  assign beat_nxt  = beat_q + 1'b1;
  assign nxt_addr  = beat_addr(held_addr, held_size, beat_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      wvalid <= 1'b0;
      wlast  <= 1'b0;
      beat_q <= '0;
      wdata  <= '0;
      wstrb  <= '0;
    end else if (start) begin
      wvalid <= 1'b1;
      beat_q <= '0;
      wdata  <= beat_data('0);
      wstrb  <= lane_mask(cmd_addr[OFF_W-1:0], cmd_size);
      wlast  <= (cmd_len == '0);
    end else if (w_hs) begin
      if (wlast) begin
        wvalid <= 1'b0;
        wlast  <= 1'b0;
      end else begin
        beat_q <= beat_nxt;
        wdata  <= beat_data(beat_nxt);
        wstrb  <= lane_mask(nxt_addr[OFF_W-1:0], held_size);
        wlast  <= (beat_nxt == held_len);
      end
    end
  end

  a_r4_w_hold: assert property (@(posedge clk) disable iff (rst)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast)));

  a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
    w_last_hs |=> !wvalid);

  a_r7_strobe_live: assert property (@(posedge clk) disable iff (rst)
    wvalid |-> (wstrb != '0));

endmodule

// File: rtl/axi_bw_ctrl.sv
module axi_bw_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  output logic       start,
  output logic       busy,
  input  logic       aw_hs,
  input  logic       w_last_hs,
  input  logic       bvalid,
  input  logic [1:0] bresp,
  output logic       bready,
  output logic       done,
  output logic [1:0] done_resp,
  output logic       done_err
);
  import axi_bw_pkg::*;

  bw_state_e state_q;
  logic      aw_done_q;
  logic      w_done_q;
  logic      aw_fin;
  logic      w_fin;
  logic      b_hs;

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = !cmd_ready;
  assign start     = cmd_valid && cmd_ready;
  assign aw_fin    = aw_done_q || aw_hs;
  assign w_fin     = w_done_q || w_last_hs;
  assign b_hs      = bvalid && bready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
      bready    <= 1'b0;
      done      <= 1'b0;
      done_resp <= RESP_OKAY;
      done_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_XFER;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
          end
        end
        ST_XFER: begin
          // Either handshake may come first, or both on the same edge.
          aw_done_q <= aw_fin;
          w_done_q  <= w_fin;
          if (aw_fin && w_fin) begin
            state_q <= ST_RESP;
            bready  <= 1'b1;
          end
        end
        ST_RESP: begin
          if (b_hs) begin
            bready    <= 1'b0;
            done      <= 1'b1;
            done_resp <= bresp;
            done_err  <= (bresp == RESP_SLVERR) || (bresp == RESP_DECERR);
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_busy_from_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));

  a_r9_bready_holds: assert property (@(posedge clk) disable iff (rst)
    (bready && !bvalid) |=> bready);

  a_r10_done_after_b: assert property (@(posedge clk) disable iff (rst)
    b_hs |=> (done && !busy));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/axi_burst_writer.sv
module axi_burst_writer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [2:0]          cmd_size,
  output logic                busy,
  output logic                done,
  output logic [1:0]          done_resp,
  output logic                done_err,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp
);

  logic start;
  logic aw_hs;
  logic w_hs;
  logic w_last_hs;

  assign m_awburst = axi_bw_pkg::BURST_INCR;

  axi_bw_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .start     (start),
    .busy      (busy),
    .aw_hs     (aw_hs),
    .w_last_hs (w_last_hs),
    .bvalid    (m_bvalid),
    .bresp     (m_bresp),
    .bready    (m_bready),
    .done      (done),
    .done_resp (done_resp),
    .done_err  (done_err)
  );

  axi_bw_addr_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_aw (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmd_addr (cmd_addr),
    .cmd_len  (cmd_len),
    .cmd_size (cmd_size),
    .awready  (m_awready),
    .awvalid  (m_awvalid),
    .awaddr   (m_awaddr),
    .awlen    (m_awlen),
    .awsize   (m_awsize),
    .aw_hs    (aw_hs)
  );

  axi_bw_data_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_w (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_size  (cmd_size),
    .held_addr (m_awaddr),
    .held_len  (m_awlen),
    .held_size (m_awsize),
    .wready    (m_wready),
    .wvalid    (m_wvalid),
    .wdata     (m_wdata),
    .wstrb     (m_wstrb),
    .wlast     (m_wlast),
    .w_hs      (w_hs),
    .w_last_hs (w_last_hs)
  );

  // R5: data phase opens together with the address phase.
  a_r5_w_with_aw: assert property (@(posedge clk) disable iff (rst)
    $rose(m_awvalid) |-> m_wvalid);

  // R9: response phase only once both request channels are quiet.
  a_r9_bready_quiet: assert property (@(posedge clk) disable iff (rst)
    m_bready |-> (!m_awvalid && !m_wvalid && !w_hs));

endmodule

// File: tb/axi_burst_writer_test.sv
module axi_burst_writer_test;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 8;
  localparam int NB     = DATA_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic [2:0]        cmd_size = '0;
  logic busy, done, done_err;
  logic [1:0] done_resp;
  logic m_awvalid, m_wvalid, m_wlast, m_bready;
  logic m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
  logic [1:0] m_bresp = 2'b00;
  logic [ADDR_W-1:0] m_awaddr;
  logic [LEN_W-1:0]  m_awlen;
  logic [2:0]        m_awsize;
  logic [1:0]        m_awburst;
  logic [DATA_W-1:0] m_wdata;
  logic [NB-1:0]     m_wstrb;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  axi_burst_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
    .busy(busy), .done(done), .done_resp(done_resp), .done_err(done_err),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
    .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid),
    .m_bready(m_bready), .m_bresp(m_bresp)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Byte-walk model of the lane enables.
  function automatic logic [NB-1:0] exp_strb(input longint start, input int size, input int n);
    longint span, a, blk_end;
    logic [NB-1:0] m;
    span = longint'(1) << size;
    if (n == 0) a = start;
    else a = (start / span) * span + longint'(n) * span;
    blk_end = (a / span) * span + span;
    m = '0;
    for (longint b = a; b < blk_end; b++) m[int'(b % NB)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] exp_data(input int n);
    logic [DATA_W-1:0] d;
    for (int k = 0; k < DATA_W / 32; k++)
      d[32*k +: 32] = 32'hD500_0000 + (32'(k) << 16) + 32'(n);
    return d;
  endfunction

  task automatic run_burst(input logic [ADDR_W-1:0] addr, input int len, input int size,
                           input int mode, input logic [1:0] resp);
    int c = 0, wb = 0, bcnt = 0;
    bit aw_got = 0, fin = 0, awr, wr, bv;
    bit p_awv = 0, p_awr = 0, p_wv = 0, p_wr = 0;
    logic [ADDR_W-1:0] p_awaddr = '0;
    logic [LEN_W-1:0] p_awlen = '0;
    logic [2:0] p_awsize = '0;
    logic [DATA_W-1:0] p_wdata = '0;
    logic [NB-1:0] p_wstrb = '0;
    logic p_wlast = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = addr; cmd_len = LEN_W'(len); cmd_size = 3'(size);
    @(negedge clk);
    chk(busy && !cmd_ready, "R2 busy after accept", {62'd0, busy, cmd_ready}, 64'h2);
    chk(m_awvalid == 1'b1, "R2 awvalid after accept", 64'(m_awvalid), 64'h1);
    chk(m_wvalid == 1'b1, "R5 wvalid with awvalid", 64'(m_wvalid), 64'h1);
    // R2: a request held while busy must be ignored.
    cmd_addr = ~addr; cmd_len = 8'hA5; cmd_size = 3'd2;
    while (!fin && c < 400) begin
      if (p_awv && !p_awr)
        chk(m_awvalid && m_awaddr == p_awaddr && m_awlen == p_awlen && m_awsize == p_awsize,
            "R3 aw hold", 64'(m_awaddr), 64'(p_awaddr));
      if (p_wv && !p_wr)
        chk(m_wvalid && m_wdata == p_wdata && m_wstrb == p_wstrb && m_wlast == p_wlast,
            "R4 w hold", m_wdata, p_wdata);
      if (m_bready)
        chk(aw_got && wb == len + 1, "R9 bready early", 64'(wb), 64'(len + 1));
      if (m_wvalid && wb > len)
        chk(1'b0, "R6 extra beat", 64'(wb), 64'(len));
      if (aw_got && m_awvalid)
        chk(1'b0, "R3 aw repeated", 64'(m_awvalid), 64'h0);
      case (mode)
        0: begin awr = 1; wr = 1; end
        1: begin wr = 1; awr = m_wvalid && (wb == len); end
        default: begin awr = (c >= 3); wr = c[0]; end
      endcase
      if (m_awvalid && awr) begin
        chk(m_awaddr == addr && m_awlen == LEN_W'(len) && m_awsize == 3'(size) && m_awburst == 2'b01,
            "R2 aw payload", {m_awaddr, m_awlen, 13'd0, m_awsize, m_awburst},
            {addr, LEN_W'(len), 13'd0, 3'(size), 2'b01});
        aw_got = 1;
      end
      if (m_wvalid && wr && wb <= len) begin
        chk(m_wdata == exp_data(wb), "R8 wdata", m_wdata, exp_data(wb));
        chk(m_wstrb == exp_strb(longint'(addr), size, wb), "R7 wstrb", 64'(m_wstrb),
            64'(exp_strb(longint'(addr), size, wb)));
        chk(m_wlast == (wb == len), "R6 wlast", 64'(m_wlast), 64'(wb == len));
        wb++;
      end
      bv = 0;
      if (m_bready) begin
        bv = (bcnt >= mode);
        bcnt++;
        if (bv) begin fin = 1; cmd_valid = 1'b0; end
      end
      m_awready = awr; m_wready = wr; m_bvalid = bv; m_bresp = resp;
      p_awv = m_awvalid; p_awr = awr; p_awaddr = m_awaddr; p_awlen = m_awlen; p_awsize = m_awsize;
      p_wv = m_wvalid; p_wr = wr; p_wdata = m_wdata; p_wstrb = m_wstrb; p_wlast = m_wlast;
      @(negedge clk);
      c++;
    end
    chk(fin, "R9 response reached", 64'(fin), 64'h1);
    chk(aw_got && wb == len + 1, "R6 beat count", 64'(wb), 64'(len + 1));
    chk(done == 1'b1 && !busy && cmd_ready, "R10 done pulse", {61'd0, done, busy, cmd_ready}, 64'h5);
    chk(done_resp == resp, "R10 resp", 64'(done_resp), 64'(resp));
    chk(done_err == resp[1], "R10 err flag", 64'(done_err), 64'(resp[1]));
    m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0;
    @(negedge clk);
    chk(!done && !m_awvalid && !m_wvalid && !busy, "R2 no new burst",
        {60'd0, done, m_awvalid, m_wvalid, busy}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lens[5] = '{0, 1, 2, 3, 15};
    int bno = 0;
    repeat (3) @(negedge clk);
    chk(!m_awvalid && !m_wvalid && !m_wlast && !m_bready && !busy && !done,
        "R1 in reset", {58'd0, m_awvalid, m_wvalid, m_wlast, m_bready, busy, done}, 64'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!m_awvalid && !m_wvalid && !m_wlast && !m_bready && !busy && cmd_ready,
        "R1 after reset", {58'd0, m_awvalid, m_wvalid, m_wlast, m_bready, busy, cmd_ready}, 64'h1);
    for (int sz = 0; sz < 4; sz++)
      for (int li = 0; li < 5; li++)
        for (int off = 0; off < 8; off++)
          for (int md = 0; md < 3; md++) begin
            run_burst(32'h0000_1000 + 32'(off), lens[li], sz, md, 2'(bno % 4));
            bno++;
          end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule